// File: doc/BRIEF.md
# Flash Write-Status Reporter

This block models the status side of a parallel flash device while an internal program or erase runs. A one-cycle program-start or erase-start pulse begins an operation of a set number of clock cycles. During that time, reads return a status byte instead of array data, and an active-low ready line is pulled low. When the operation ends, the block applies its effect to a small internal byte array. Reads then return stored data again, so the effect of each operation can be read back.

Status encoding while busy is as follows. Bit 7 is a polling bit whose meaning depends on the operation. Bit 6 flips on each read. Bits 5..0 read as zero. The array is split into sectors that are selected by the top address bits. Each sector has a protect flag. A program aimed at a protected sector, or an erase with no unprotected selected sector, stays busy for its own abort timeout and changes nothing.

Top module: `flash_status_reporter`

## Requirements
- R1: During a program, a read returns bit 7 equal to the inverse of bit 7 of the data being programmed. After completion, a read of the program address returns the programmed byte.
- R2: During an erase, a read returns bit 7 as 0. After completion, every byte of each erased sector reads 8'hFF, so bit 7 reads 1.
- R3: While busy, each read returns bit 6 as 0 on the first read after the start, and the value inverts on every later read at any address. Bits 5..0 read 0. Once the block is idle, bit 6 is no longer a status bit.
- R4: An accepted start makes busy_n low from the next clock edge. For an unprotected operation, busy_n stays low for exactly PROG_CYCLES (program) or ERASE_CYCLES (erase) cycles.
- R5: A program whose address lies in a sector with its sect_prot bit set keeps busy_n low for PROT_PROG_CYCLES cycles. The stored byte is left unchanged.
- R6: An erase in which no selected sector is unprotected keeps busy_n low for PROT_ERASE_CYCLES cycles and changes no byte. This includes the case where erase_sel is zero.
- R7: An erase that selects both protected and unprotected sectors lasts ERASE_CYCLES. It sets only the unprotected selected sectors to 8'hFF.
- R8: A start pulse seen while busy is ignored. If prog_start and erase_start arrive together while idle, only the program is started.
- R9: While idle, a read strobe loads rd_data with the array byte at rd_addr on the next edge. Without a strobe, rd_data holds its value.
- R10: After reset, busy_n is 1, rd_data is 0, and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | One-cycle pulse that starts a program |
| erase_start | input | 1 | One-cycle pulse that starts an erase |
| op_addr | input | ADDR_W | Byte address of a program |
| op_data | input | 8 | Byte to program |
| erase_sel | input | 2**SECT_W | Sectors chosen for an erase, one bit per sector |
| sect_prot | input | 2**SECT_W | Protect flag per sector |
| rd_strobe | input | 1 | Read cycle request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result: status byte while busy, array byte while idle |
| busy_n | output | 1 | Low while an operation runs, high when ready |

## Verification
The hardest situation to reach from the ports is a read, or a second start, that lands on the same edge where an operation ends. At that edge the block must still report status, and the next read must return data. The stimulus runs reads on every cycle through each operation, and it fires a second start in the middle of a busy period. It also covers a protected program, an all-protected erase, a mixed erase and simultaneous start pulses. A cycle-exact reference model is compared against both outputs on every clock, so any error of one cycle in the busy window or in the toggle phase is caught.

// File: rtl/flash_status_reporter.sv
module flash_status_reporter #(
  parameter int ADDR_W            = 4,
  parameter int SECT_W            = 2,
  parameter int PROG_CYCLES       = 50,
  parameter int ERASE_CYCLES      = 2000,
  parameter int PROT_PROG_CYCLES  = 100,
  parameter int PROT_ERASE_CYCLES = 10000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_start,
  input  logic                     erase_start,
  input  logic [ADDR_W-1:0]        op_addr,
  input  logic [7:0]               op_data,
  input  logic [(1<<SECT_W)-1:0]   erase_sel,
  input  logic [(1<<SECT_W)-1:0]   sect_prot,
  input  logic                     rd_strobe,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [7:0]               rd_data,
  output logic                     busy_n
);
  localparam int NSECT = 1 << SECT_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int M1    = PROG_CYCLES > ERASE_CYCLES ? PROG_CYCLES : ERASE_CYCLES;
  localparam int M2    = PROT_PROG_CYCLES > PROT_ERASE_CYCLES ? PROT_PROG_CYCLES : PROT_ERASE_CYCLES;
  localparam int MAXC  = M1 > M2 ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [7:0]        mem [DEPTH];
  logic              busy, is_erase, skip, tog;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic [NSECT-1:0]  wipe_q;
  logic [NSECT-1:0]  wipe_now;
  logic [7:0]        status;

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SECT_W];
  endfunction

  assign wipe_now = erase_sel & ~sect_prot;
  assign status   = {is_erase ? 1'b0 : ~data_q[7], tog, 6'b0};
  assign busy_n   = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      is_erase <= 1'b0;
      skip     <= 1'b0;
      tog      <= 1'b0;
      cnt      <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      wipe_q   <= '0;
      rd_data  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          if (!is_erase && !skip) mem[addr_q] <= data_q;
          if (is_erase)
            for (int i = 0; i < DEPTH; i++)
              if (wipe_q[sect_of(ADDR_W'(i))]) mem[i] <= 8'hFF;
        end
      end else if (prog_start) begin
        busy     <= 1'b1;
        is_erase <= 1'b0;
        tog      <= 1'b0;
        addr_q   <= op_addr;
        data_q   <= op_data;
        skip     <= sect_prot[sect_of(op_addr)];
        cnt      <= sect_prot[sect_of(op_addr)] ? CNT_W'(PROT_PROG_CYCLES) : CNT_W'(PROG_CYCLES);
      end else if (erase_start) begin
        busy     <= 1'b1;
        is_erase <= 1'b1;
        tog      <= 1'b0;
        wipe_q   <= wipe_now;
        skip     <= (wipe_now == '0);
        cnt      <= (wipe_now == '0) ? CNT_W'(PROT_ERASE_CYCLES) : CNT_W'(ERASE_CYCLES);
      end
      if (rd_strobe) begin
        rd_data <= busy ? status : mem[rd_addr];
        if (busy) tog <= ~tog;
      end
    end
  end

  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && (prog_start || erase_start)) |=> !busy_n);
  a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_erase && rd_strobe) |=> (rd_data[7] == 1'b0));
  a_r3_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe) |=> (rd_data[5:0] == 6'b0));
  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_strobe) |=> (tog != $past(tog)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));
  a_r8_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_W'(1)) |=> ($stable(is_erase) && $stable(addr_q) && $stable(data_q)));
  a_r4_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));
endmodule

// File: tb/flash_status_reporter_test.sv
module flash_status_reporter_test;
  localparam int AW = 4, SW = 2, PC = 5, EC = 12, PPC = 8, PEC = 20;
  logic clk = 0, rst_n = 0;
  logic ps = 0, es = 0, rd = 0;
  logic [AW-1:0] oa = 0, ra = 0;
  logic [7:0] od = 0;
  logic [3:0] sel = 0, prot = 0;
  logic [7:0] rd_data;
  logic busy_n;

  flash_status_reporter #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
    .PROT_PROG_CYCLES(PPC), .PROT_ERASE_CYCLES(PEC)) uut (
    .clk(clk), .rst_n(rst_n), .prog_start(ps), .erase_start(es), .op_addr(oa), .op_data(od),
    .erase_sel(sel), .sect_prot(prot), .rd_strobe(rd), .rd_addr(ra), .rd_data(rd_data), .busy_n(busy_n));

  always #5 clk = ~clk;

  int vectors = 0, errs = 0;
  string req = "R10";
  int mem [16];
  bit m_busy = 0, m_er = 0, m_skip = 0, m_tog = 0;
  int m_cnt = 0, m_addr = 0;
  logic [7:0] m_data = 0, m_rd = 0;
  logic [3:0] m_wipe = 0;

  task automatic check(input string r, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic model();
    bit was_busy = m_busy;
    if (rd) begin
      if (was_busy) begin m_rd = {m_er ? 1'b0 : ~m_data[7], m_tog, 6'b0}; m_tog = ~m_tog; end
      else m_rd = mem[ra][7:0];
    end
    if (was_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0;
        if (!m_er && !m_skip) mem[m_addr] = m_data;
        if (m_er) for (int i = 0; i < 16; i++) if (m_wipe[i/4]) mem[i] = 8'hFF;
      end
    end else if (ps) begin
      m_busy = 1; m_er = 0; m_tog = 0; m_addr = oa; m_data = od;
      m_skip = prot[oa/4]; m_cnt = m_skip ? PPC : PC;
    end else if (es) begin
      m_busy = 1; m_er = 1; m_tog = 0; m_wipe = sel & ~prot;
      m_skip = (m_wipe == 0); m_cnt = m_skip ? PEC : EC;
    end
  endtask

  task automatic step(input bit p, input bit e, input bit r, input int a, input int rda);
    @(negedge clk);
    ps = p; es = e; rd = r; oa = AW'(a); ra = AW'(rda);
    @(posedge clk);
    model();
    #1;
    check(req, rd_data, m_rd);
    check(req, {7'b0, busy_n}, {7'b0, ~m_busy});
  endtask

  task automatic read_through(input int n, input int a);
    for (int k = 0; k < n; k++) step(0, 0, 1, 0, (a + k) % 16);
  endtask

  task automatic read_all();
    for (int k = 0; k < 16; k++) step(0, 0, 1, 0, k);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    #23 rst_n = 1;
    #1;
    // R10: reset state
    check("R10", rd_data, 8'h00);
    check("R10", {7'b0, busy_n}, 8'h01);
    req = "R9"; read_all();

    // R1 R3 R4: program 0xA5 at 5, read every cycle, stray start mid-op (R8)
    req = "R1"; od = 8'hA5;
    step(1, 0, 0, 5, 0);
    req = "R3"; read_through(2, 5);
    req = "R8"; sel = 4'hF; step(0, 1, 1, 0, 9); step(1, 0, 0, 7, 0);
    req = "R4"; read_through(PC, 3);
    req = "R1"; step(0, 0, 1, 0, 5); read_all();

    // R1: bit 7 clear data, reads at other address, partial reads
    od = 8'h3C; step(1, 0, 0, 2, 0);
    step(0, 0, 1, 0, 11); step(0, 0, 0, 0, 0); step(0, 0, 1, 0, 2);
    read_through(PC, 2); read_all();

    // R2: erase sector 0
    req = "R2"; sel = 4'b0001; prot = 0;
    step(0, 1, 1, 0, 2);
    read_through(EC + 2, 0); read_all();

    // R7: mixed erase
    req = "R7"; od = 8'h11; step(1, 0, 0, 6, 0); read_through(PC + 1, 6);
    od = 8'h22; step(1, 0, 0, 13, 0); read_through(PC + 1, 13);
    sel = 4'b1110; prot = 4'b1010; step(0, 1, 0, 0, 0);
    read_through(EC + 1, 4); read_all();

    // R5: protected program
    req = "R5"; prot = 4'b0010; od = 8'h00;
    step(1, 0, 1, 6, 6); read_through(PPC + 2, 6); read_all();

    // R6: all-protected erase, then empty selection
    req = "R6"; sel = 4'b0010; step(0, 1, 0, 0, 0); read_through(PEC + 2, 4); read_all();
    sel = 4'b0000; prot = 0; step(0, 1, 1, 0, 1); read_through(PEC + 2, 1); read_all();

    // R8: simultaneous pulses, program wins
    req = "R8"; sel = 4'b1111; od = 8'h5A;
    step(1, 1, 0, 9, 0); read_through(PC + 2, 9); read_all();
    // R3: idle reads do not toggle
    req = "R3"; read_through(4, 9);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule